// File: doc/BRIEF.md
# Memory-Mapped Console and Power-Control Slave

This block is a slave on a simple 32-bit load/store bus. It claims one fixed address window and serves a small console with a serial-port style register set, plus a system-control register. A store to the console data register sends the low byte of the store out on a transmit byte stream. A load from the same register takes one byte from a receive byte stream. A status register reports whether a received byte is waiting, and it always reports the transmitter as ready. A store to the system-control register produces exactly one of three single-cycle pulses: poweroff, restart or fault.

The bus takes one access per cycle through a valid/ready handshake. Ready depends only on whether the address falls inside the window. Load data comes back one cycle after the address, marked by a response-valid strobe. The transmit stream never applies backpressure. The receive stream is handed its ready only in the cycle where a load actually consumes a byte.

Top module: `mmio_console_ctrl`

## Requirements
- R1: `bus_ready` is high exactly when `bus_addr` lies in [0x1000_0000, 0x1200_0000). Accesses outside that range are never acknowledged and have no effect.
- R2: `rsp_valid` is high for one cycle, the cycle after each accepted load, carrying `rsp_rdata`. An accepted store never raises `rsp_valid`.
- R3: An accepted store to 0x1000_0000 raises `tx_valid` for one cycle, the cycle after acceptance, with `tx_data` equal to bits [7:0] of the store data. Bits [31:8] of the store data have no effect.
- R4: A load from 0x1000_0005 returns 0x61 when `rx_valid` is high in the accept cycle and 0x60 otherwise. Bit 6 and bit 5 are always 1. Bit 0 is the byte-waiting flag. This load consumes nothing.
- R5: A load from 0x1000_0000 while `rx_valid` is high returns `rx_data` zero-extended to 32 bits, and `rx_ready` is high in the accept cycle, which consumes the byte.
- R6: A load from 0x1000_0000 while `rx_valid` is low returns 0, and `rx_ready` stays low.
- R7: `rx_ready` is never high outside the accept cycle of a load from 0x1000_0000 with `rx_valid` high.
- R8: An accepted store of exactly 0x0000_5555 to 0x1110_0000 raises `poweroff_pulse` for one cycle, the cycle after acceptance.
- R9: An accepted store of exactly 0x0000_7777 to 0x1110_0000 raises `restart_pulse` for one cycle, the cycle after acceptance.
- R10: Any other value stored to 0x1110_0000 raises `fault_pulse` for one cycle instead. At most one of the three pulses is high in any cycle.
- R11: Loads from unmapped addresses inside the window return 0. Stores to unmapped addresses inside the window produce no transmit byte and no pulse.
- R12: While reset is asserted, and in the first cycle after it is released, `rsp_valid`, `tx_valid` and all three pulses are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request present |
| bus_ready | output | 1 | Address is claimed; access accepted when both are high |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Load data valid, one cycle after acceptance |
| rsp_rdata | output | 32 | Load data |
| rx_valid | input | 1 | Receive byte waiting |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive byte consumed this cycle |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| poweroff_pulse | output | 1 | Poweroff request pulse |
| restart_pulse | output | 1 | Restart request pulse |
| fault_pulse | output | 1 | Bad system-control value pulse |

## Verification
The bench builds the block with its default parameters: the window from 0x1000_0000 up to 0x1200_0000, the register addresses above, and the codes 0x5555 and 0x7777. With these values both window edges can be reached directly. The bench probes 0x0FFF_FFFF, the first claimed address, the last claimed address 0x11FF_FFFF, and 0x1200_0000. Because the codes are matched across all 32 bits, a store of 0x0001_5555 shows that the full value is compared and must produce a fault. Back-to-back stores to the system-control register check that consecutive pulses stay separate and that only one pulse fires per cycle.

// File: rtl/mcon_pkg.sv
package mcon_pkg;

    localparam int DATA_W       = 32;
    localparam int BYTE_W       = 8;
    localparam int LSR_RX_BIT   = 0;
    localparam int LSR_THRE_BIT = 5;
    localparam int LSR_TEMT_BIT = 6;

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_SYSCTL = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic              rsp_valid;
        logic [DATA_W-1:0] rsp_rdata;
        logic              tx_valid;
        logic [BYTE_W-1:0] tx_data;
        logic              poweroff;
        logic              restart;
        logic              fault;
    } mcon_state_t;

endpackage

// File: rtl/mcon_decode.sv
module mcon_decode
    import mcon_pkg::*;
#(
    parameter int                 ADDR_W      = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE    = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  WIN_LIMIT   = 32'h1200_0000,
    parameter logic [ADDR_W-1:0]  DATA_ADDR   = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  STATUS_ADDR = 32'h1000_0005,
    parameter logic [ADDR_W-1:0]  SYSCTL_ADDR = 32'h1110_0000
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_window_o,
    output reg_sel_e          sel_o
);

    always_comb begin
        in_window_o = (addr_i >= WIN_BASE) && (addr_i < WIN_LIMIT);
        sel_o       = SEL_NONE;
        if (in_window_o) begin
            if (addr_i == DATA_ADDR)        sel_o = SEL_DATA;
            else if (addr_i == STATUS_ADDR) sel_o = SEL_STATUS;
            else if (addr_i == SYSCTL_ADDR) sel_o = SEL_SYSCTL;
        end
    end

endmodule

// File: rtl/mcon_console.sv
module mcon_console
    import mcon_pkg::*;
(
    input  reg_sel_e          sel_i,
    input  logic              rd_fire_i,
    input  logic              rx_valid_i,
    input  logic [BYTE_W-1:0] rx_data_i,
    output logic              rx_ready_o,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        rdata_o = '0;
        case (sel_i)
            SEL_DATA: begin
                if (rx_valid_i) rdata_o[BYTE_W-1:0] = rx_data_i;
            end
            SEL_STATUS: begin
                rdata_o[LSR_THRE_BIT] = 1'b1;
                rdata_o[LSR_TEMT_BIT] = 1'b1;
                rdata_o[LSR_RX_BIT]   = rx_valid_i;
            end
            default: ;
        endcase
        rx_ready_o = rd_fire_i && (sel_i == SEL_DATA) && rx_valid_i;
    end

endmodule

// File: rtl/mcon_sysctl.sv
module mcon_sysctl
    import mcon_pkg::*;
#(
    parameter logic [DATA_W-1:0] POWEROFF_CODE = 32'h0000_5555,
    parameter logic [DATA_W-1:0] RESTART_CODE  = 32'h0000_7777
) (
    input  logic              fire_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              poweroff_o,
    output logic              restart_o,
    output logic              fault_o
);

    always_comb begin
        poweroff_o = 1'b0;
        restart_o  = 1'b0;
        fault_o    = 1'b0;
        if (fire_i) begin
            if (wdata_i == POWEROFF_CODE)     poweroff_o = 1'b1;
            else if (wdata_i == RESTART_CODE) restart_o  = 1'b1;
            else                              fault_o    = 1'b1;
        end
    end

endmodule

// File: rtl/mmio_console_ctrl.sv
module mmio_console_ctrl
    import mcon_pkg::*;
#(
    parameter int                 ADDR_W        = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE      = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  WIN_LIMIT     = 32'h1200_0000,
    parameter logic [ADDR_W-1:0]  DATA_ADDR     = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  STATUS_ADDR   = 32'h1000_0005,
    parameter logic [ADDR_W-1:0]  SYSCTL_ADDR   = 32'h1110_0000,
    parameter logic [DATA_W-1:0]  POWEROFF_CODE = 32'h0000_5555,
    parameter logic [DATA_W-1:0]  RESTART_CODE  = 32'h0000_7777
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    output logic              bus_ready,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              poweroff_pulse,
    output logic              restart_pulse,
    output logic              fault_pulse
);

    logic              in_window;
    reg_sel_e          sel;
    logic              rd_fire;
    logic              wr_fire;
    logic [DATA_W-1:0] rd_word;
    logic              sys_off, sys_rst, sys_flt;
    mcon_state_t       st_d, st_q;

    mcon_decode #(
        .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT),
        .DATA_ADDR(DATA_ADDR), .STATUS_ADDR(STATUS_ADDR), .SYSCTL_ADDR(SYSCTL_ADDR)
    ) u_decode (
        .addr_i      (bus_addr),
        .in_window_o (in_window),
        .sel_o       (sel)
    );

    assign bus_ready = in_window;
    assign rd_fire   = bus_valid && bus_ready && !bus_write;
    assign wr_fire   = bus_valid && bus_ready && bus_write;

    mcon_console u_console (
        .sel_i      (sel),
        .rd_fire_i  (rd_fire),
        .rx_valid_i (rx_valid),
        .rx_data_i  (rx_data),
        .rx_ready_o (rx_ready),
        .rdata_o    (rd_word)
    );

    mcon_sysctl #(
        .POWEROFF_CODE(POWEROFF_CODE), .RESTART_CODE(RESTART_CODE)
    ) u_sysctl (
        .fire_i     (wr_fire && (sel == SEL_SYSCTL)),
        .wdata_i    (bus_wdata),
        .poweroff_o (sys_off),
        .restart_o  (sys_rst),
        .fault_o    (sys_flt)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rsp_valid = rd_fire;
        st_d.tx_valid  = wr_fire && (sel == SEL_DATA);
        st_d.poweroff  = sys_off;
        st_d.restart   = sys_rst;
        st_d.fault     = sys_flt;
        if (rd_fire)       st_d.rsp_rdata = rd_word;
        if (st_d.tx_valid) st_d.tx_data   = bus_wdata[BYTE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid      = st_q.rsp_valid;
    assign rsp_rdata      = st_q.rsp_rdata;
    assign tx_valid       = st_q.tx_valid;
    assign tx_data        = st_q.tx_data;
    assign poweroff_pulse = st_q.poweroff;
    assign restart_pulse  = st_q.restart;
    assign fault_pulse    = st_q.fault;

endmodule

// File: rtl/mcon_checker.sv
module mcon_checker
    import mcon_pkg::*;
#(
    parameter int                 ADDR_W        = 32,
    parameter logic [ADDR_W-1:0]  WIN_BASE      = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  WIN_LIMIT     = 32'h1200_0000,
    parameter logic [ADDR_W-1:0]  DATA_ADDR     = 32'h1000_0000,
    parameter logic [ADDR_W-1:0]  STATUS_ADDR   = 32'h1000_0005,
    parameter logic [ADDR_W-1:0]  SYSCTL_ADDR   = 32'h1110_0000,
    parameter logic [DATA_W-1:0]  POWEROFF_CODE = 32'h0000_5555
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_ready,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata,
    input logic              rx_valid,
    input logic              rx_ready,
    input logic              tx_valid,
    input logic              poweroff_pulse,
    input logic              restart_pulse,
    input logic              fault_pulse
);

    logic acc;
    assign acc = bus_valid && bus_ready;

    AST_NO_ACK_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr < WIN_BASE || bus_addr >= WIN_LIMIT) |-> !bus_ready); // R1

    AST_RSP_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !bus_write) |=> rsp_valid); // R2

    AST_NO_RSP_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && bus_write) |=> !rsp_valid); // R2

    AST_TX_FROM_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(acc && bus_write && bus_addr == DATA_ADDR)); // R3

    AST_STATUS_FIXED_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && $past(acc && !bus_write && bus_addr == STATUS_ADDR))
        |-> (rsp_rdata[LSR_TEMT_BIT:LSR_THRE_BIT] == 2'b11)); // R4

    AST_RX_READY_ONLY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (rx_valid && acc && !bus_write && bus_addr == DATA_ADDR)); // R7

    AST_POWEROFF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        poweroff_pulse |-> $past(acc && bus_write && bus_addr == SYSCTL_ADDR
                                 && bus_wdata == POWEROFF_CODE)); // R8

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({poweroff_pulse, restart_pulse, fault_pulse})); // R10

endmodule

bind mmio_console_ctrl mcon_checker #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LIMIT(WIN_LIMIT),
    .DATA_ADDR(DATA_ADDR), .STATUS_ADDR(STATUS_ADDR), .SYSCTL_ADDR(SYSCTL_ADDR),
    .POWEROFF_CODE(POWEROFF_CODE)
) u_mcon_checker (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .tx_valid(tx_valid), .poweroff_pulse(poweroff_pulse),
    .restart_pulse(restart_pulse), .fault_pulse(fault_pulse)
);

// File: tb/test_mmio_console_ctrl.sv
module test_mmio_console_ctrl;

    localparam logic [31:0] A_DATA   = 32'h1000_0000;
    localparam logic [31:0] A_STATUS = 32'h1000_0005;
    localparam logic [31:0] A_SYS    = 32'h1110_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic        bus_ready, rsp_valid, rx_ready, tx_valid;
    logic [31:0] rsp_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0, tx_data;
    logic        poweroff_pulse, restart_pulse, fault_pulse;

    always #4 clk = ~clk;

    mmio_console_ctrl i_mmio_console_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_ready(bus_ready),
        .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rx_valid(rx_valid),
        .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid),
        .tx_data(tx_data), .poweroff_pulse(poweroff_pulse),
        .restart_pulse(restart_pulse), .fault_pulse(fault_pulse)
    );

    // kinds: 0 load response, 1 tx byte, 2 poweroff, 3 restart, 4 fault
    typedef struct {
        int          kind;
        logic [31:0] val;
        string       req;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [31:0] val, input string req);
        exp_t e;
        e.kind = kind; e.val = val; e.req = req;
        q.push_back(e);
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] d,
                          input bit rxv, input logic [7:0] rxd, input string req);
        bit exp_rdy;
        exp_rdy = (a >= 32'h1000_0000) && (a < 32'h1200_0000);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
        rx_valid = rxv; rx_data = rxd;
        #1;
        check({req, "/R1 ready"}, {31'd0, bus_ready}, {31'd0, exp_rdy});
        check({req, "/R7 rx_ready"}, {31'd0, rx_ready},
              {31'd0, exp_rdy && !wr && a == A_DATA && rxv});
        if (exp_rdy) begin
            if (!wr) begin
                if (a == A_DATA)        push(0, rxv ? {24'd0, rxd} : 32'd0, req);
                else if (a == A_STATUS) push(0, rxv ? 32'h61 : 32'h60, req);
                else                    push(0, 32'd0, req);
            end else if (a == A_DATA) begin
                push(1, {24'd0, d[7:0]}, req);
            end else if (a == A_SYS) begin
                if (d == 32'h5555)      push(2, 32'd1, req);
                else if (d == 32'h7777) push(3, 32'd1, req);
                else                    push(4, 32'd1, req);
            end
        end
        @(posedge clk);
        #1;
        bus_valid = 1'b0; rx_valid = 1'b0;
    endtask

    // monitor: compares each produced event against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int   nact;
            int   kind;
            logic [31:0] val;
            nact = int'(rsp_valid) + int'(tx_valid) + int'(poweroff_pulse)
                 + int'(restart_pulse) + int'(fault_pulse);
            kind = 0; val = '0;
            if (rsp_valid)           begin kind = 0; val = rsp_rdata; end
            else if (tx_valid)       begin kind = 1; val = {24'd0, tx_data}; end
            else if (poweroff_pulse) begin kind = 2; val = 32'd1; end
            else if (restart_pulse)  begin kind = 3; val = 32'd1; end
            else if (fault_pulse)    begin kind = 4; val = 32'd1; end
            if (nact > 1) begin
                check("R10 single event", nact, 1);
            end else if (nact == 1) begin
                if (q.size() == 0) begin
                    check("R11 unexpected event kind", kind, 99);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check({e.req, " kind"}, kind, e.kind);
                    check({e.req, " value"}, val, e.val);
                end
            end
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        done = 1'b1;
        finish_run();
    end

    initial begin
        // R12: outputs quiet in reset and right after release
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 rsp_valid", {31'd0, rsp_valid}, 0);
        check("R12 tx_valid", {31'd0, tx_valid}, 0);
        check("R12 pulses", {29'd0, poweroff_pulse, restart_pulse, fault_pulse}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", {28'd0, rsp_valid, tx_valid, poweroff_pulse,
              restart_pulse | fault_pulse}, 0);

        // R1: window edges
        access(0, 32'h0FFF_FFFF, 0, 0, 0, "R1 below");
        access(0, 32'h1200_0000, 0, 0, 0, "R1 limit");
        access(1, 32'h2000_0000, 32'h5555, 0, 0, "R1 outside store");
        access(0, 32'h11FF_FFFF, 0, 1, 8'h44, "R11 last addr");
        access(0, 32'h1000_0000, 0, 0, 0, "R6 empty pop");

        // R3 tx, upper bits ignored
        access(1, A_DATA, 32'hABCD_12C3, 0, 0, "R3 tx");
        access(1, A_DATA, 32'hFFFF_FF00, 0, 0, "R3 tx zero");

        // R4 status
        access(0, A_STATUS, 0, 0, 0, "R4 idle");
        access(0, A_STATUS, 0, 1, 8'h9A, "R4 waiting");

        // R5 / R6 data reads, R2 back-to-back responses
        access(0, A_DATA, 0, 1, 8'h9A, "R5 pop");
        access(0, A_DATA, 0, 1, 8'hFF, "R5 pop ff");
        access(0, A_DATA, 0, 0, 8'h77, "R6 nothing");

        // R8..R10 system control, back to back
        access(1, A_SYS, 32'h0000_5555, 0, 0, "R8 poweroff");
        access(1, A_SYS, 32'h0000_7777, 0, 0, "R9 restart");
        access(1, A_SYS, 32'h0000_5556, 0, 0, "R10 bad value");
        access(1, A_SYS, 32'h0001_5555, 0, 0, "R10 high bits");
        access(1, A_SYS, 32'h0000_5555, 0, 0, "R8 again");

        // R11 unmapped stores inside window do nothing; R2 no response on store
        access(1, 32'h1000_0004, 32'h5555, 0, 0, "R11 unmapped store");
        access(1, A_STATUS, 32'h41, 0, 0, "R11 status store");
        access(0, 32'h1100_BFF8, 0, 0, 0, "R11 unmapped load");

        repeat (4) @(negedge clk);
        check("R2 scoreboard drained", q.size(), 0);
        done = 1'b1;
        finish_run();
    end

endmodule